// File: doc/BRIEF.md
# Test Access Port with Four-Instruction Decode

This block is the device side of a boundary-scan test port. It runs the sixteen-state test controller from the test clock and mode-select input, and holds a five-bit instruction register. The register decodes four instructions: bypass, identification, sample/preload and external test. Serial data entering on TDI leaves on TDO through one of three paths. The first is a one-bit bypass stage. The second is a 32-bit identification stage that captures 0x16410041. The third is the serial port of an external boundary-cell chain, which this block selects and sequences through state strobes.

A power-on reset puts the controller into Test-Logic-Reset. Entering Test-Logic-Reset, by that reset or by holding TMS high, makes identification the active instruction. A data scan straight after reset therefore returns the identification value. All shifting is least-significant bit first. TDO changes on the falling edge of TCK and is enabled only while a shift state is active.

Top module: `jtag_tap_port`

## Requirements
- R1: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. The instruction in effect then becomes identification.
- R2: The controller follows the standard sixteen-state transition graph, sampling TMS on each rising TCK edge.
- R3: After power-on reset the active instruction is identification (opcode 00001). A 32-bit data scan then shifts out 0x16410041, LSB first, so the first bit out is 1.
- R4: In Capture-IR the instruction shift stage loads 00001. An instruction scan therefore shifts out 1, then four zeros.
- R5: The instruction in effect changes only on the rising edge that leaves Update-IR, or in Test-Logic-Reset. A value shifted into the instruction stage has no effect on the selection outputs before then.
- R6: Opcode 11111 (bypass) places a one-bit stage between TDI and TDO. That stage captures 0, so a data scan returns 0 followed by TDI delayed by one bit.
- R7: Any opcode other than 11111, 00001, 00010 and 00000 behaves exactly as bypass.
- R8: Opcode 00010 (sample/preload) raises bscanSel with extestActive low, and TDO in Shift-DR follows bsrTdo.
- R9: Opcode 00000 (external test) raises both bscanSel and extestActive, and TDO in Shift-DR follows bsrTdo.
- R10: tdoEn is high only while the controller is in Shift-IR or Shift-DR. TDO and tdoEn change on the falling edge of TCK.
- R11: The last bit of a scan moves on the same rising edge that takes the controller into Exit1 with TMS high.
- R12: drCapture, drShift and drUpdate are each high exactly while the controller is in Capture-DR, Shift-DR and Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| powerOnRst | input | 1 | Asynchronous active-high power-on reset to Test-Logic-Reset |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in, also fed to the boundary chain |
| bsrTdo | input | 1 | Serial output of the external boundary-cell chain |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdoEn | output | 1 | Output enable for TDO |
| bscanSel | output | 1 | Boundary chain is the selected data register |
| extestActive | output | 1 | External test instruction is in effect |
| drCapture | output | 1 | Controller is in Capture-DR |
| drShift | output | 1 | Controller is in Shift-DR |
| drUpdate | output | 1 | Controller is in Update-DR |

## Verification
The assertions assume that TMS and TDI are stable around each rising TCK edge and that bsrTdo is stable around each falling edge. They also assume that power-on reset is asserted once before the first edge that matters. The bench changes every input one nanosecond after a falling edge, far from both clock edges, and samples outputs one nanosecond after the following falling edge. Every scan walks a legal TMS path, so the run-length counter behind the reset assertion only sees real TMS histories.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_SEL_DR   = 4'd2,
    ST_CAP_DR   = 4'd3,
    ST_SHIFT_DR = 4'd4,
    ST_EX1_DR   = 4'd5,
    ST_PAUSE_DR = 4'd6,
    ST_EX2_DR   = 4'd7,
    ST_UPD_DR   = 4'd8,
    ST_SEL_IR   = 4'd9,
    ST_CAP_IR   = 4'd10,
    ST_SHIFT_IR = 4'd11,
    ST_EX1_IR   = 4'd12,
    ST_PAUSE_IR = 4'd13,
    ST_EX2_IR   = 4'd14,
    ST_UPD_IR   = 4'd15
  } tapState_t;

  typedef struct packed {
    logic testReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobe_t;

  localparam int IR_BITS = 5;
  localparam int ID_BITS = 32;
  localparam logic [IR_BITS-1:0] OPC_BYPASS = 5'b11111;
  localparam logic [IR_BITS-1:0] OPC_IDCODE = 5'b00001;
  localparam logic [IR_BITS-1:0] OPC_SAMPLE = 5'b00010;
  localparam logic [IR_BITS-1:0] OPC_EXTEST = 5'b00000;
  localparam logic [ID_BITS-1:0] ID_DEFAULT = 32'h16410041;

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       powerOnRst,
  input  logic       tms,
  output tapStrobe_t strobe
);

  tapState_t state, nextState;

  always_comb begin
    unique case (state)
      ST_RESET:    nextState = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nextState = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nextState = tms ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_SHIFT_DR: nextState = tms ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_EX1_DR:   nextState = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nextState = tms ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   nextState = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nextState = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nextState = tms ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_SHIFT_IR: nextState = tms ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_EX1_IR:   nextState = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nextState = tms ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   nextState = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      default:     nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst) state <= ST_RESET;
    else            state <= nextState;
  end

  always_comb begin
    strobe.testReset = (state == ST_RESET);
    strobe.captureIr = (state == ST_CAP_IR);
    strobe.shiftIr   = (state == ST_SHIFT_IR);
    strobe.updateIr  = (state == ST_UPD_IR);
    strobe.captureDr = (state == ST_CAP_DR);
    strobe.shiftDr   = (state == ST_SHIFT_DR);
    strobe.updateDr  = (state == ST_UPD_DR);
  end

  // Run length of TMS-high edges, saturating at five, used only by the check below
  logic [2:0] tmsHighRun;
  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)          tmsHighRun <= 3'd0;
    else if (!tms)           tmsHighRun <= 3'd0;
    else if (tmsHighRun < 5) tmsHighRun <= tmsHighRun + 3'd1;
  end

  assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (powerOnRst)
    (tmsHighRun == 3'd5) |-> (state == ST_RESET));

  assert_scan_exit_R11: assert property (@(posedge tck) disable iff (powerOnRst)
    ((state == ST_SHIFT_DR) && tms) |=> (state == ST_EX1_DR));

  assert_ir_exit_R2: assert property (@(posedge tck) disable iff (powerOnRst)
    ((state == ST_SEL_IR) && !tms) |=> (state == ST_CAP_IR));

  assert_strobe_onehot_R12: assert property (@(posedge tck) disable iff (powerOnRst)
    $onehot0({strobe.captureDr, strobe.shiftDr, strobe.updateDr,
              strobe.captureIr, strobe.shiftIr, strobe.updateIr, strobe.testReset}));

endmodule

// File: rtl/jtag_tap_dp.sv
module jtag_tap_dp
  import jtag_tap_pkg::*;
#(
  parameter int                  IR_W      = IR_BITS,
  parameter int                  ID_W      = ID_BITS,
  parameter logic [ID_W-1:0]     ID_VALUE  = ID_DEFAULT,
  parameter logic [IR_W-1:0]     OP_BYPASS = OPC_BYPASS,
  parameter logic [IR_W-1:0]     OP_IDCODE = OPC_IDCODE,
  parameter logic [IR_W-1:0]     OP_SAMPLE = OPC_SAMPLE,
  parameter logic [IR_W-1:0]     OP_EXTEST = OPC_EXTEST
) (
  input  logic       tck,
  input  logic       powerOnRst,
  input  tapStrobe_t strobe,
  input  logic       tdi,
  input  logic       bsrTdo,
  output logic       tdo,
  output logic       tdoEn,
  output logic       bscanSel,
  output logic       extestActive
);

  localparam logic [ID_W-1:0] ID_LOAD    = {ID_VALUE[ID_W-1:1], 1'b1};
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irActive;
  logic [ID_W-1:0] idShift;
  logic            bypassBit;
  logic            selId, selBsr, selExtest;
  logic            drOut;

  // Instruction decode: anything unlisted falls through to bypass
  always_comb begin
    selId     = (irActive == OP_IDCODE);
    selExtest = (irActive == OP_EXTEST);
    selBsr    = selExtest || (irActive == OP_SAMPLE);
  end

  assign bscanSel     = selBsr;
  assign extestActive = selExtest;

  // Instruction shift stage
  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)            irShift <= IR_CAPTURE;
    else if (strobe.captureIr) irShift <= IR_CAPTURE;
    else if (strobe.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // Instruction in effect
  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)            irActive <= OP_IDCODE;
    else if (strobe.testReset) irActive <= OP_IDCODE;
    else if (strobe.updateIr)  irActive <= irShift;
  end

  // Identification stage
  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)                      idShift <= ID_LOAD;
    else if (strobe.captureDr && selId)  idShift <= ID_LOAD;
    else if (strobe.shiftDr && selId)    idShift <= {tdi, idShift[ID_W-1:1]};
  end

  // Bypass stage
  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)            bypassBit <= 1'b0;
    else if (strobe.captureDr) bypassBit <= 1'b0;
    else if (strobe.shiftDr)   bypassBit <= tdi;
  end

  always_comb begin
    if (selId)       drOut = idShift[0];
    else if (selBsr) drOut = bsrTdo;
    else             drOut = bypassBit;
  end

  // Output retimed to the falling edge
  always_ff @(negedge tck or posedge powerOnRst) begin
    if (powerOnRst) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= strobe.shiftIr ? irShift[0] : drOut;
      tdoEn <= strobe.shiftIr || strobe.shiftDr;
    end
  end

  assert_ir_hold_R5: assert property (@(posedge tck) disable iff (powerOnRst)
    (!strobe.updateIr && !strobe.testReset) |=> $stable(irActive));

  assert_reset_loads_id_R3: assert property (@(posedge tck) disable iff (powerOnRst)
    strobe.testReset |=> (irActive == OP_IDCODE));

  assert_id_lsb_one_R3: assert property (@(posedge tck) disable iff (powerOnRst)
    (strobe.captureDr && selId) |=> idShift[0]);

  assert_ir_capture_R4: assert property (@(posedge tck) disable iff (powerOnRst)
    strobe.captureIr |=> (irShift == IR_CAPTURE));

  assert_tdo_enable_R10: assert property (@(posedge tck) disable iff (powerOnRst)
    tdoEn == (strobe.shiftIr || strobe.shiftDr));

  assert_extest_implies_sel_R9: assert property (@(posedge tck) disable iff (powerOnRst)
    extestActive |-> bscanSel);

endmodule

// File: rtl/jtag_tap_port.sv
module jtag_tap_port
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W     = IR_BITS,
  parameter int              ID_W     = ID_BITS,
  parameter logic [ID_W-1:0] ID_VALUE = ID_DEFAULT
) (
  input  logic tck,
  input  logic powerOnRst,
  input  logic tms,
  input  logic tdi,
  input  logic bsrTdo,
  output logic tdo,
  output logic tdoEn,
  output logic bscanSel,
  output logic extestActive,
  output logic drCapture,
  output logic drShift,
  output logic drUpdate
);

  tapStrobe_t strobe;

  jtag_tap_ctrl uCtrl (
    .tck        (tck),
    .powerOnRst (powerOnRst),
    .tms        (tms),
    .strobe     (strobe)
  );

  jtag_tap_dp #(
    .IR_W     (IR_W),
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) uDp (
    .tck          (tck),
    .powerOnRst   (powerOnRst),
    .strobe       (strobe),
    .tdi          (tdi),
    .bsrTdo       (bsrTdo),
    .tdo          (tdo),
    .tdoEn        (tdoEn),
    .bscanSel     (bscanSel),
    .extestActive (extestActive)
  );

  assign drCapture = strobe.captureDr;
  assign drShift   = strobe.shiftDr;
  assign drUpdate  = strobe.updateDr;

endmodule

// File: tb/sim_jtag_tap_port.sv
`timescale 1ns/100ps
module sim_jtag_tap_port;

  logic tck = 1'b0;
  logic powerOnRst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsrTdo = 1'b0;
  logic tdo, tdoEn, bscanSel, extestActive, drCapture, drShift, drUpdate;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 tck = ~tck;

  jtag_tap_port u0 (
    .tck(tck), .powerOnRst(powerOnRst), .tms(tms), .tdi(tdi), .bsrTdo(bsrTdo),
    .tdo(tdo), .tdoEn(tdoEn), .bscanSel(bscanSel), .extestActive(extestActive),
    .drCapture(drCapture), .drShift(drShift), .drUpdate(drUpdate)
  );

  localparam logic [31:0] ID_EXP = 32'h16410041;

  typedef struct packed {
    logic [4:0] op;
    logic [1:0] kind;   // 0 bypass, 1 identification, 2 boundary chain
    logic       ext;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{5'b11111, 2'd0, 1'b0},
    '{5'b00001, 2'd1, 1'b0},
    '{5'b00010, 2'd2, 1'b0},
    '{5'b00000, 2'd2, 1'b1},
    '{5'b10101, 2'd0, 1'b0},
    '{5'b00111, 2'd0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One TCK period: inputs set after a falling edge, outputs read after the next one
  task automatic step(input logic tmsV, input logic tdiV);
    tms = tmsV;
    tdi = tdiV;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic loadIr(input logic [4:0] op, output logic [4:0] cap);
    step(1'b1, 1'b0);            // Select-DR
    step(1'b1, 1'b0);            // Select-IR
    step(1'b0, 1'b0);            // Capture-IR
    step(1'b0, 1'b0);            // Shift-IR
    cap[0] = tdo;
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i]);
      if (i < 4) cap[i+1] = tdo;
    end
    check("R11 exit1-ir tdoEn", {31'd0, tdoEn}, 32'd0);
    step(1'b1, 1'b0);            // Update-IR
    step(1'b0, 1'b0);            // Run-Test/Idle
  endtask

  task automatic scanDr(input int n, input logic [31:0] din, input logic [31:0] bsr,
                        input logic chkStrobes, output logic [31:0] got);
    got = '0;
    step(1'b1, 1'b0);            // Select-DR
    step(1'b0, 1'b0);            // Capture-DR
    if (chkStrobes) check("R12 capture strobe", {29'd0, drCapture, drShift, drUpdate}, 32'b100);
    bsrTdo = bsr[0];
    step(1'b0, 1'b0);            // Shift-DR
    if (chkStrobes) begin
      check("R12 shift strobe", {29'd0, drCapture, drShift, drUpdate}, 32'b010);
      check("R10 tdoEn in shift-dr", {31'd0, tdoEn}, 32'd1);
    end
    got[0] = tdo;
    for (int i = 0; i < n; i++) begin
      if (i + 1 < 32) bsrTdo = bsr[i+1];
      step(i == n - 1, din[i]);
      if (i < n - 1) got[i+1] = tdo;
    end
    if (chkStrobes) check("R11 exit1-dr tdoEn", {31'd0, tdoEn}, 32'd0);
    step(1'b1, 1'b0);            // Update-DR
    if (chkStrobes) check("R12 update strobe", {29'd0, drCapture, drShift, drUpdate}, 32'b001);
    step(1'b0, 1'b0);            // Run-Test/Idle
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [4:0]  cap;
    logic [31:0] got;
    logic [31:0] exp;
    logic [7:0]  pat;
    logic [7:0]  bpat;
    pat  = 8'b1011_0010;
    bpat = 8'b0110_1101;

    #12;
    @(negedge tck);
    #1;
    check("R3 reset bscanSel/extest", {30'd0, bscanSel, extestActive}, 32'd0);
    check("R10 reset tdoEn", {31'd0, tdoEn}, 32'd0);
    check("R12 reset strobes", {29'd0, drCapture, drShift, drUpdate}, 32'd0);
    powerOnRst = 1'b0;
    step(1'b1, 1'b0);            // stays in Test-Logic-Reset
    check("R2 reset holds with tms high", {31'd0, tdoEn}, 32'd0);
    step(1'b0, 1'b0);            // Run-Test/Idle

    // R3: identification read straight after reset
    scanDr(32, 32'hFFFF_0000, 32'd0, 1'b1, got);
    check("R3 idcode after reset", got, ID_EXP);

    // Table walk over opcodes
    for (int v = 0; v < 6; v++) begin
      loadIr(VECS[v].op, cap);
      check("R4 ir capture pattern", {27'd0, cap}, 32'b00001);
      check("R8 R9 bscanSel", {31'd0, bscanSel}, {31'd0, VECS[v].kind == 2'd2});
      check("R9 extestActive", {31'd0, extestActive}, {31'd0, VECS[v].ext});
      scanDr(8, {24'd0, pat}, {24'd0, bpat}, 1'b0, got);
      case (VECS[v].kind)
        2'd0:    exp = {24'd0, pat[6:0], 1'b0};
        2'd1:    exp = {24'd0, ID_EXP[7:0]};
        default: exp = {24'd0, bpat};
      endcase
      if (VECS[v].kind == 2'd0 && VECS[v].op != 5'b11111)
        check("R7 undefined opcode acts as bypass", got, exp);
      else if (VECS[v].kind == 2'd0)
        check("R6 bypass path", got, exp);
      else if (VECS[v].kind == 2'd1)
        check("R3 idcode instruction", got, exp);
      else
        check("R8 R9 boundary path", got, exp);
    end

    // R5: instruction in effect holds until the edge leaving Update-IR
    loadIr(5'b00000, cap);
    check("R9 extest loaded", {31'd0, extestActive}, 32'd1);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(i == 4, 1'b1);
    check("R5 hold in exit1-ir", {30'd0, bscanSel, extestActive}, 32'b11);
    step(1'b1, 1'b0);            // Update-IR
    check("R5 hold in update-ir", {30'd0, bscanSel, extestActive}, 32'b11);
    step(1'b0, 1'b0);            // Run-Test/Idle
    check("R5 new instruction after update", {30'd0, bscanSel, extestActive}, 32'b00);

    // R1: leave Shift-DR with five TMS-high edges, then identification is back in effect
    loadIr(5'b00010, cap);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);   // Shift-DR
    check("R10 tdoEn in shift-dr", {31'd0, tdoEn}, 32'd1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    check("R1 tdoEn low in reset", {31'd0, tdoEn}, 32'd0);
    step(1'b0, 1'b0);            // Run-Test/Idle
    check("R1 instruction back to identification", {31'd0, bscanSel}, 32'd0);
    scanDr(32, 32'd0, 32'd0, 1'b0, got);
    check("R1 idcode after tms reset", got, ID_EXP);

    // R2: pause and exit2 path resumes shifting through bypass
    loadIr(5'b11111, cap);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);   // Shift-DR, tdo = captured 0
    check("R6 bypass captures zero", {31'd0, tdo}, 32'd0);
    step(1'b1, 1'b1);            // shift in 1, to Exit1-DR
    step(1'b0, 1'b0);            // Pause-DR
    check("R2 pause-dr tdoEn low", {31'd0, tdoEn}, 32'd0);
    step(1'b1, 1'b0);            // Exit2-DR
    step(1'b0, 1'b0);            // Shift-DR
    check("R2 resume shift keeps bypass bit", {30'd0, tdoEn, tdo}, 32'b11);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule